// File: doc/BRIEF.md
# Serial PHY Management Frame Master

This block turns one 32-bit maintenance word, written by a host through a single-cycle strobe, into a clause-22 management transaction on a management clock line and a bidirectional data line. The word is already a complete frame. It holds the start code, the operation, the PHY and register numbers, the turnaround pattern and 16 data bits. The block sends a run of preamble ones, then all 32 bits of the word most significant first, with the line changing on the falling clock edge.

On a read, the block releases the data line for the turnaround and data bits. It samples the PHY's reply on the rising clock edges and shifts the 16 returned bits into the low half of the held word. The host polls an idle flag in a status word, then reads the maintenance word back. The port only works while a management-enable input is high. Clearing that input abandons a frame in progress.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the idle flag (status bit 2) is 1, the management clock is 0, the output enable is 0 and the maintenance word is zero.
- R2: While a frame runs, the management clock has a period of CLK_DIV system clocks (48 by default): low for the first half, then high. While idle it stays low.
- R3: A write strobe accepted while idle and enabled clears the idle flag from the next cycle. The flag stays 0 for exactly (PRE_BITS+32)*CLK_DIV cycles, which is 3072 by default, and then returns to 1.
- R4: The frame on the data line is PRE_BITS ones followed by word bits 31 down to 0. The line changes only together with a falling management clock edge.
- R5: When word bits 29:28 equal 2'b10 (read), the output enable is low for the last 18 frame bits (word bits 17:0, the turnaround and data). Any other operation value drives all bits.
- R6: On a read, the data line is sampled at each rising clock edge of the last 16 frame bits. The samples are stored into word bits 15:0, first sample in bit 15. Bits 31:16 keep the value that was written.
- R7: A read with no PHY driving (the line pulled high) stores 16'hFFFF. The frame length and idle timing are the same as for any other read.
- R8: A write strobe while a frame runs is ignored: the held word and the frame in progress do not change.
- R9: A write strobe while the management-enable input is low is ignored: idle stays 1 and the held word does not change.
- R10: Clearing the management-enable input during a frame returns the idle flag to 1, the clock to 0 and the output enable to 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mgmt_en | input | 1 | Management port enable |
| wr_stb | input | 1 | One-cycle maintenance word write strobe |
| wr_word | input | 32 | Maintenance word to send |
| maint_word | output | 32 | Held maintenance word; low half holds read data after a read |
| status_word | output | 32 | Status; bit 2 is the idle flag, the other bits are zero |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The assertions assume that the host strobes a word only while the idle flag is set. They also assume that the enable input drops only as a deliberate abort, so any strobe outside that window must be shown to have no effect. The stimulus issues strobes at idle for writes, reads and reads with no PHY present. It places the deliberate violations (a strobe in mid-frame, a strobe with the port disabled) at points where their lack of effect can be seen in the held word and the idle flag. The PHY model drives the data line only during the bench's own reckoning of the read data window, and leaves it pulled high at all other times.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_W  = 32;
  localparam int DATA_W   = 16;
  localparam int IDLE_BIT = 2;
  // frame bits (counted from the first bit after preamble) at which a read releases the line
  localparam int REL_POS  = 14;
  localparam int CAP_POS  = 16;

  typedef enum logic [1:0] {
    OPC_WRITE = 2'b01,
    OPC_READ  = 2'b10
  } mgmt_op_e;

  typedef struct packed {
    logic [1:0]        sof;
    logic [1:0]        op;
    logic [4:0]        phy;
    logic [4:0]        regn;
    logic [1:0]        ta;
    logic [DATA_W-1:0] data;
  } maint_word_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV = 48
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 2;
  localparam int HALF = DIV / 2;

  logic [CW-1:0] cnt;

  assign rise_evt = run && (cnt == CW'(HALF - 1));
  assign fall_evt = run && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      if (fall_evt) cnt <= '0;
      else          cnt <= cnt + 1'b1;
      if (rise_evt)      mdc <= 1'b1;
      else if (fall_evt) mdc <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
#(
  parameter int PRE_BITS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              abort,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic [FRAME_W-1:0] word,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              cap_vld,
  output logic              cap_bit
);
  localparam int TOTAL = PRE_BITS + FRAME_W;
  localparam int IW    = $clog2(TOTAL + 1);

  logic [IW-1:0] idx;
  maint_word_t   w;
  logic          is_rd;

  assign w     = maint_word_t'(word);
  assign is_rd = (w.op == OPC_READ);

  function automatic logic bit_at(input int i, input logic [FRAME_W-1:0] v);
    int k;
    if (i < PRE_BITS) return 1'b1;
    k = FRAME_W - 1 - (i - PRE_BITS);
    return v[k[4:0]];
  endfunction

  function automatic logic released(input int i, input logic rd);
    return rd && (i >= PRE_BITS + REL_POS);
  endfunction

  assign cap_vld = busy && rise_evt && is_rd && (int'(idx) >= PRE_BITS + CAP_POS);
  assign cap_bit = mdio_i;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy    <= 1'b0;
      idx     <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
    end else if (start) begin
      busy    <= 1'b1;
      idx     <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b1;
    end else if (busy && fall_evt) begin
      if (int'(idx) == TOTAL - 1) begin
        busy    <= 1'b0;
        idx     <= '0;
        mdio_o  <= 1'b1;
        mdio_oe <= 1'b0;
      end else begin
        idx     <= idx + 1'b1;
        mdio_o  <= bit_at(int'(idx) + 1, word);
        mdio_oe <= !released(int'(idx) + 1, is_rd);
      end
    end
  end
endmodule

// File: rtl/mdio_maint_reg.sv
module mdio_maint_reg
  import mdio_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_word,
  input  logic               cap_vld,
  input  logic               cap_bit,
  output logic [FRAME_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
    end else if (load) begin
      word <= load_word;
    end else if (cap_vld) begin
      word[DATA_W-1:0] <= {word[DATA_W-2:0], cap_bit};
    end
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int CLK_DIV  = 48,
  parameter int PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        mgmt_en,
  input  logic        wr_stb,
  input  logic [31:0] wr_word,
  output logic [31:0] maint_word,
  output logic [31:0] status_word,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic busy, accept, abort, run;
  logic rise_evt, fall_evt, cap_vld, cap_bit;

  assign accept = wr_stb && mgmt_en && !busy;
  assign abort  = busy && !mgmt_en;
  assign run    = busy && mgmt_en;

  always_comb begin
    status_word           = '0;
    status_word[IDLE_BIT] = ~busy;
  end

  mdio_clk_div #(.DIV(CLK_DIV)) u_div (
    .clk(clk), .rst(rst), .run(run),
    .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio_maint_reg u_reg (
    .clk(clk), .rst(rst), .load(accept), .load_word(wr_word),
    .cap_vld(cap_vld), .cap_bit(cap_bit), .word(maint_word)
  );

  mdio_frame_seq #(.PRE_BITS(PRE_BITS)) u_seq (
    .clk(clk), .rst(rst), .start(accept), .abort(abort),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .word(maint_word),
    .mdio_i(mdio_i), .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .cap_vld(cap_vld), .cap_bit(cap_bit)
  );
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk (
  input logic        clk,
  input logic        rst,
  input logic        mgmt_en,
  input logic        wr_stb,
  input logic        idle,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic [31:0] maint_word
);
  // R3
  a_r3_idle_drops: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && mgmt_en && idle) |=> !idle);
  // R2
  a_r2_mdc_quiet: assert property (@(posedge clk) disable iff (rst)
    idle |-> !mdc);
  // R5
  a_r5_oe_idle: assert property (@(posedge clk) disable iff (rst)
    idle |-> !mdio_oe);
  // R4
  a_r4_hold_high: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> $stable(mdio_o));
  // R4
  a_r4_hold_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));
  // R8
  a_r8_upper_stable: assert property (@(posedge clk) disable iff (rst)
    (!idle && $past(!idle)) |-> $stable(maint_word[31:16]));
  // R9
  a_r9_disabled_ignored: assert property (@(posedge clk) disable iff (rst)
    (idle && !mgmt_en) |=> (idle && $stable(maint_word)));
  // R10
  a_r10_abort: assert property (@(posedge clk) disable iff (rst)
    (!idle && !mgmt_en) |=> (idle && !mdc && !mdio_oe));
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
  .clk(clk), .rst(rst), .mgmt_en(mgmt_en), .wr_stb(wr_stb),
  .idle(status_word[2]), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .maint_word(maint_word)
);

// File: tb/mdio_mgmt_master_tb.sv
module mdio_mgmt_master_tb;
  localparam int DIV = 48;
  localparam int PRE = 32;
  localparam int TOT = PRE + 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mgmt_en = 1'b0;
  logic        wr_stb = 1'b0;
  logic [31:0] wr_word = '0;
  logic [31:0] maint_word, status_word;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // behavioural reference state
  bit          m_busy = 0, m_read = 0, m_mdc = 0, m_oe = 0, m_o = 1;
  int          m_ph = 0, m_bit = 0;
  logic [31:0] m_word = '0;
  bit          phy_present = 0;
  logic [15:0] phy_reply = '0;

  always #4 clk = ~clk;

  mdio_mgmt_master #(.CLK_DIV(DIV), .PRE_BITS(PRE)) u_dut (
    .clk(clk), .rst(rst), .mgmt_en(mgmt_en), .wr_stb(wr_stb), .wr_word(wr_word),
    .maint_word(maint_word), .status_word(status_word), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  function automatic bit bit_at(int i, logic [31:0] w);
    if (i < PRE) return 1'b1;
    return w[31 - (i - PRE)];
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      if (errors < 30) $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_busy = 0; m_ph = 0; m_bit = 0; m_word = '0; m_mdc = 0; m_oe = 0; m_o = 1;
    end else if (m_busy && !mgmt_en) begin
      m_busy = 0; m_ph = 0; m_bit = 0; m_mdc = 0; m_oe = 0; m_o = 1;
    end else if (m_busy) begin
      m_ph++;
      if (m_ph == DIV/2) begin
        m_mdc = 1;
        if (m_read && m_bit >= PRE + 16) m_word[15:0] = {m_word[14:0], mdio_i};
      end
      if (m_ph == DIV) begin
        m_ph = 0; m_mdc = 0; m_bit++;
        if (m_bit == TOT) begin
          m_busy = 0; m_bit = 0; m_oe = 0; m_o = 1;
        end else begin
          m_o  = bit_at(m_bit, m_word);
          m_oe = !(m_read && m_bit >= PRE + 14);
        end
      end
    end else if (wr_stb && mgmt_en) begin
      m_word = wr_word; m_read = (wr_word[29:28] == 2'b10);
      m_busy = 1; m_ph = 0; m_bit = 0; m_oe = 1; m_o = 1;
    end
  end

  // PHY model and per-cycle comparison
  always @(negedge clk) begin
    mdio_i <= (phy_present && m_busy && m_read && m_bit >= PRE + 16) ?
              phy_reply[15 - (m_bit - PRE - 16)] : 1'b1;
    if (!rst) begin
      check(mdc == m_mdc, "R2 mdc", {31'b0, mdc}, {31'b0, m_mdc});
      check(mdio_oe == m_oe, "R5 oe", {31'b0, mdio_oe}, {31'b0, m_oe});
      if (m_oe) check(mdio_o == m_o, "R4 mdio", {31'b0, mdio_o}, {31'b0, m_o});
      check(status_word == {29'b0, !m_busy, 2'b0}, "R3 status", status_word, {29'b0, !m_busy, 2'b0});
      check(maint_word == m_word, "R6 word", maint_word, m_word);
    end
  end

  task automatic issue(logic [31:0] w);
    @(negedge clk); wr_word = w; wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic wait_idle(output int low);
    low = status_word[2] ? 0 : 1;
    while (1) begin
      @(negedge clk);
      if (status_word[2]) break;
      low++;
    end
  endtask

  localparam logic [31:0] WR_W  = {2'b01, 2'b01, 5'd3, 5'd9, 2'b10, 16'hA5C3};
  localparam logic [31:0] RD_W  = {2'b01, 2'b10, 5'd1, 5'd1, 2'b10, 16'h0000};
  localparam logic [31:0] RD_W2 = {2'b01, 2'b10, 5'd31, 5'd2, 2'b10, 16'h1234};

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int low;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(status_word[2] == 1'b1, "R1 idle", status_word, 32'h4);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 lines", {30'b0, mdc, mdio_oe}, 32'h0);
    check(maint_word == 32'h0, "R1 word", maint_word, 32'h0);
    mgmt_en = 1'b1;

    // R3 R4 write frame and idle duration
    issue(WR_W);
    check(status_word[2] == 1'b0, "R3 busy after accept", status_word, 32'h0);
    wait_idle(low);
    check(low == TOT * DIV, "R3 busy length", low, TOT * DIV);
    check(maint_word == WR_W, "R4 word after write", maint_word, WR_W);

    // R5 R6 read with PHY reply
    phy_present = 1; phy_reply = 16'h5A3C;
    issue(RD_W);
    wait_idle(low);
    check(low == TOT * DIV, "R5 read length", low, TOT * DIV);
    check(maint_word == {RD_W[31:16], 16'h5A3C}, "R6 read data", maint_word, {RD_W[31:16], 16'h5A3C});

    // R7 read with no PHY present
    phy_present = 0;
    issue(RD_W2);
    wait_idle(low);
    check(low == TOT * DIV, "R7 read length", low, TOT * DIV);
    check(maint_word == {RD_W2[31:16], 16'hFFFF}, "R7 all ones", maint_word, {RD_W2[31:16], 16'hFFFF});

    // R8 strobe during a frame is ignored
    phy_present = 1; phy_reply = 16'h0F0F;
    issue(RD_W);
    repeat (100) @(negedge clk);
    issue(WR_W);
    check(maint_word[31:16] == RD_W[31:16], "R8 upper kept", maint_word, RD_W);
    wait_idle(low);
    check(maint_word == {RD_W[31:16], 16'h0F0F}, "R8 frame intact", maint_word, {RD_W[31:16], 16'h0F0F});

    // R9 strobe while disabled is ignored
    mgmt_en = 1'b0;
    issue(WR_W);
    check(status_word[2] == 1'b1, "R9 still idle", status_word, 32'h4);
    check(maint_word == {RD_W[31:16], 16'h0F0F}, "R9 word kept", maint_word, {RD_W[31:16], 16'h0F0F});
    repeat (60) @(negedge clk);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R9 lines quiet", {30'b0, mdc, mdio_oe}, 32'h0);
    mgmt_en = 1'b1;

    // R10 abort mid-frame, then recover with a read
    issue(WR_W);
    repeat (500) @(negedge clk);
    mgmt_en = 1'b0;
    @(negedge clk);
    check(status_word[2] == 1'b1, "R10 idle after abort", status_word, 32'h4);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R10 lines released", {30'b0, mdc, mdio_oe}, 32'h0);
    mgmt_en = 1'b1;
    phy_reply = 16'h8001;
    issue(RD_W2);
    wait_idle(low);
    check(maint_word == {RD_W2[31:16], 16'h8001}, "R6 read after abort", maint_word, {RD_W2[31:16], 16'h8001});

    repeat (10) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule